// File: doc/BRIEF.md
# Motor Stall Protection Timer

This block guards a brushless motor drive against a stalled rotor. While the drive is in run mode and the speed loop reports that it is out of lock, an internal up/down count rises at a programmable rate. When the count reaches a programmable limit, a registered protect output latches high. The surrounding drive logic uses that output to switch off its low-side switches. The latch holds through any change of the lock indication. It releases only when the drive is put into stop mode, when protection is disabled, or on power-on reset.

The block models the charging capacitor of an analog stall timer as a digital accumulator. In stop mode the count does not clear at once. It drains toward zero at its own programmable rate. A short stop therefore leaves a residual count, and the next trip comes sooner than the full limit would give. When lock is regained during run, the count stops rising and drains at the same drain rate. The charge rate and the drain rate come from two prescalers. Each prescaler restarts its phase whenever its direction becomes inactive, so every trip time can be predicted to the cycle.

Top module: `stall_guard`

## Requirements
- R1: After synchronous reset, `protect_o` is low and the internal count is zero. The count is visible as the full trip time measured from the first run cycle.
- R2: With `guard_en_i`=1, `run_i`=1, `lock_n_i`=1 (1 = unlocked) and protect low, the count rises by one every `charge_div_i`+1 cycles, counted from the first cycle in that condition. A value of 0 means one step per cycle.
- R3: `protect_o` rises one cycle after the count first equals or exceeds a nonzero `trip_limit_i`. Starting from zero, the trip comes `trip_limit_i`*(`charge_div_i`+1)+1 cycles after charging begins.
- R4: Once set in run mode, `protect_o` stays high whatever `lock_n_i` does.
- R5: The first clock edge that samples `run_i`=0 clears `protect_o`.
- R6: In stop mode (`run_i`=0) the count falls by one every `drain_div_i`+1 cycles. A residual count shortens the next trip accordingly.
- R7: In run mode with lock present (`lock_n_i`=0) and protect low, the count does not clear. It falls at the drain rate, and charging resumes from the value it has reached.
- R8: The count saturates at zero, so after a long stop the next trip takes the full time.
- R9: `guard_en_i`=0 clears the count and forces `protect_o` low on the next edge, and no trip occurs while it stays low.
- R10: A `trip_limit_i` of zero never trips. The count is held at zero while the limit is zero.
- R11: The count changes by at most one per cycle. It never rises while it is at or above the limit, and it never wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| run_i | input | 1 | 1 = run mode, 0 = stop mode |
| lock_n_i | input | 1 | Speed-lock indication, 1 = unlocked |
| guard_en_i | input | 1 | 1 = protection active, 0 = disabled and cleared |
| trip_limit_i | input | CNT_W | Trip threshold in count steps, 0 = never trip |
| charge_div_i | input | DIV_W | Charge prescaler, one step per value+1 cycles |
| drain_div_i | input | DIV_W | Drain prescaler, one step per value+1 cycles |
| protect_o | output | 1 | Latched low-side shutdown request |

## Verification
The embedded assertions check several properties on every cycle:
- the count never moves by more than one step;
- the count never climbs past the limit and never drops below zero;
- a count at the limit in run mode sets the latch on the next edge;
- a set latch survives run mode;
- stop or disable clears the latch on the next edge.

The exact trip times can only be shown by the bench's scenarios, because they are not visible from a single cycle. These include the full-time trip, the shortened trip after a brief stop, the resumed climb after a relock interval, and the full-time trip after a long stop or a disable. The bench measures each one to the cycle at the output.

// File: rtl/stall_pkg.sv
package stall_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_CHARGE = 2'd1,
    MODE_DRAIN  = 2'd2,
    MODE_HOLD   = 2'd3
  } guard_mode_e;

  localparam int unsigned CH_UP   = 0;
  localparam int unsigned CH_DOWN = 1;
  localparam int unsigned NUM_CH  = 2;
endpackage

// File: rtl/stall_mode_dec.sv
module stall_mode_dec
  import stall_pkg::*;
(
  input  logic        en_i,
  input  logic        run_i,
  input  logic        lock_n_i,
  input  logic        protect_i,
  output guard_mode_e mode_o
);
  always_comb begin
    if (!en_i)            mode_o = MODE_IDLE;
    else if (!run_i)      mode_o = MODE_DRAIN;
    else if (protect_i)   mode_o = MODE_HOLD;
    else if (lock_n_i)    mode_o = MODE_CHARGE;
    else                  mode_o = MODE_DRAIN;
  end
endmodule

// File: rtl/stall_prescaler.sv
module stall_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] phase_q;

  assign tick_o = active_i && (phase_q >= div_i);

  always_ff @(posedge clk) begin
    if (rst || !active_i || tick_o) phase_q <= '0;
    else                            phase_q <= phase_q + 1'b1;
  end

  // R2: an idle prescaler restarts its phase, so no tick on the first active cycle unless div is 0
  assert_phase_restart_R2: assert property (@(posedge clk) disable iff (rst)
    (!active_i) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/stall_accum.sv
module stall_accum #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             up_tick_i,
  input  logic             dn_tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o
);
  logic at_ceiling, at_floor;

  assign at_ceiling = (count_o >= limit_i);
  assign at_floor   = (count_o == '0);

  always_ff @(posedge clk) begin
    if (rst || clear_i)                 count_o <= '0;
    else if (up_tick_i && !at_ceiling)  count_o <= count_o + 1'b1;
    else if (dn_tick_i && !at_floor)    count_o <= count_o - 1'b1;
  end

  assert_single_step_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1 ||
              count_o == $past(count_o) - 1'b1 || count_o == '0));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    (count_o >= limit_i) |=> (count_o <= $past(count_o)));

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (count_o == '0 && !up_tick_i) |=> (count_o == '0));
endmodule

// File: rtl/stall_guard.sv
module stall_guard
  import stall_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             lock_n_i,
  input  logic             guard_en_i,
  input  logic [CNT_W-1:0] trip_limit_i,
  input  logic [DIV_W-1:0] charge_div_i,
  input  logic [DIV_W-1:0] drain_div_i,
  output logic             protect_o
);
  guard_mode_e                   mode;
  logic [NUM_CH-1:0]             ch_act;
  logic [NUM_CH-1:0]             ch_tick;
  logic [NUM_CH-1:0][DIV_W-1:0]  ch_div;
  logic [CNT_W-1:0]              count;
  logic                          limit_live;
  logic                          trip_now;

  stall_mode_dec u_mode (
    .en_i      (guard_en_i),
    .run_i     (run_i),
    .lock_n_i  (lock_n_i),
    .protect_i (protect_o),
    .mode_o    (mode)
  );

  assign ch_act[CH_UP]   = (mode == MODE_CHARGE);
  assign ch_act[CH_DOWN] = (mode == MODE_DRAIN);
  assign ch_div[CH_UP]   = charge_div_i;
  assign ch_div[CH_DOWN] = drain_div_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_rate
    stall_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk      (clk),
      .rst      (rst),
      .active_i (ch_act[g]),
      .div_i    (ch_div[g]),
      .tick_o   (ch_tick[g])
    );
  end

  stall_accum #(.CNT_W(CNT_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (mode == MODE_IDLE),
    .up_tick_i (ch_tick[CH_UP]),
    .dn_tick_i (ch_tick[CH_DOWN]),
    .limit_i   (trip_limit_i),
    .count_o   (count)
  );

  assign limit_live = (trip_limit_i != '0);
  assign trip_now   = limit_live && (count >= trip_limit_i);

  always_ff @(posedge clk) begin
    if (rst || !guard_en_i || !run_i) protect_o <= 1'b0;
    else if (trip_now)                protect_o <= 1'b1;
  end

  assert_trip_next_R3: assert property (@(posedge clk) disable iff (rst)
    (guard_en_i && run_i && trip_limit_i != '0 && count >= trip_limit_i) |=> protect_o);

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (protect_o && run_i && guard_en_i) |=> protect_o);

  assert_stop_release_R5: assert property (@(posedge clk) disable iff (rst)
    (!run_i) |=> !protect_o);

  assert_disable_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (!guard_en_i) |=> (!protect_o && count == '0));

  assert_zero_limit_R10: assert property (@(posedge clk) disable iff (rst)
    (trip_limit_i == '0 && !protect_o) |=> (!protect_o || $past(trip_limit_i) != '0));
endmodule

// File: tb/tb_stall_guard.sv
module tb_stall_guard;
  localparam int CW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic          lock_n = 1'b1;
  logic          en = 1'b0;
  logic [CW-1:0] limit = '0;
  logic [DW-1:0] cdiv = '0;
  logic [DW-1:0] ddiv = '0;
  logic          protect;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  stall_guard #(.CNT_W(CW), .DIV_W(DW)) dut (
    .clk(clk), .rst(rst), .run_i(run), .lock_n_i(lock_n), .guard_en_i(en),
    .trip_limit_i(limit), .charge_div_i(cdiv), .drain_div_i(ddiv), .protect_o(protect)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // returns the number of edges until protect is first seen high, -1 if never
  task automatic measure(input int maxc, output int n);
    n = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (protect) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic t_reset;
    int n;
    @(negedge clk);
    check(protect == 1'b0, "R1 reset protect", protect, 0);
    limit = 10; cdiv = 3; ddiv = 1; en = 1; lock_n = 1; run = 1;
    measure(200, n);
    check(n == 41, "R1 R2 R3 full trip time from reset", n, 41);
  endtask

  task automatic t_latch_hold;
    lock_n = 0;
    edges(30);
    check(protect == 1'b1, "R4 latch holds with lock", protect, 1);
    lock_n = 1;
    edges(5);
    check(protect == 1'b1, "R4 latch holds unlocked", protect, 1);
  endtask

  task automatic t_short_stop;
    int n;
    run = 0;
    edges(1);
    check(protect == 1'b0, "R5 stop clears latch", protect, 0);
    edges(6);
    run = 1;
    measure(200, n);
    check(n == 13, "R6 residual shortens trip", n, 13);
  endtask

  task automatic t_long_stop;
    int n;
    run = 0;
    edges(40);
    check(protect == 1'b0, "R5 stays clear in stop", protect, 0);
    run = 1;
    measure(200, n);
    check(n == 41, "R8 drained to zero full time", n, 41);
  endtask

  task automatic t_relock;
    int n;
    run = 0;
    edges(40);
    run = 1; lock_n = 1;
    edges(24);
    lock_n = 0;
    edges(4);
    check(protect == 1'b0, "R7 no trip while locked", protect, 0);
    lock_n = 1;
    measure(200, n);
    check(n == 25, "R7 resume from drained value", n, 25);
  endtask

  task automatic t_fast_rate;
    int n;
    run = 0;
    edges(40);
    cdiv = 0; limit = 5; run = 1;
    measure(100, n);
    check(n == 6, "R2 R3 one step per cycle", n, 6);
    cdiv = 3; limit = 10;
  endtask

  task automatic t_disable;
    int n;
    en = 1; run = 1; lock_n = 1;
    @(negedge clk);
    en = 0;
    edges(1);
    check(protect == 1'b0, "R9 disable clears latch", protect, 0);
    edges(100);
    check(protect == 1'b0, "R9 no trip while disabled", protect, 0);
    en = 1;
    edges(20);
    en = 0;
    edges(1);
    en = 1;
    measure(200, n);
    check(n == 41, "R9 disable cleared the count", n, 41);
  endtask

  task automatic t_zero_limit;
    int n;
    en = 0;
    edges(1);
    en = 1; limit = 0; run = 1; lock_n = 1;
    edges(100);
    check(protect == 1'b0, "R10 zero limit never trips", protect, 0);
    run = 0;
    edges(1);
    limit = 3; run = 1;
    measure(100, n);
    check(n == 13, "R10 count held at zero", n, 13);
  endtask

  initial begin
    edges(3);
    rst = 0;
    t_reset();
    t_latch_hold();
    t_short_stop();
    t_long_stop();
    t_relock();
    t_fast_rate();
    t_disable();
    t_zero_limit();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule